// File: doc/BRIEF.md
# E3 Transmit Payload Input Interface

This block sits between system-side terminal equipment and an E3 transmit framer. It takes payload either one bit at a time or four bits at a time. It tells the system side when to present data, and it hands the framer one captured bit per bit period, together with a pulse that marks the last bit of every 1536-bit frame.

The clock domain is modelled as one fast clock, `clk_i`, with two strobes. `rec_en_i` marks a bit period of the clock recovered from the receive line, and `loc_en_i` marks a bit period of a locally supplied 34.368 MHz clock.

A 3-bit mode code, sampled only while the synchronous reset `srst_i` is high, picks one of six operating modes. Each mode sets three things:
- the input width: serial or nibble;
- the timing source: loop-timed from the recovered strobe, or locally timed;
- the frame timing: free-running, or aligned to a frame reference input.

In nibble modes the nibble strobe runs at one quarter of the bit rate.

Top module: `e3_tx_payload_if`

## Requirements
- R1: `mode_i` is decoded as follows, and 0 or 7 behave as 1. The decoded mode is loaded only in cycles where `srst_i` is high, so a change of `mode_i` at any other time has no effect. Asynchronous reset selects mode 1.

  | Code | Input  | Timing | Frame     |
  |------|--------|--------|-----------|
  | 1    | serial | loop   | free      |
  | 2    | serial | local  | aligned   |
  | 3    | serial | local  | free      |
  | 4    | nibble | loop   | free      |
  | 5    | nibble | local  | aligned   |
  | 6    | nibble | local  | free      |

- R2: Modes 1 and 4 advance one bit period per clock cycle with `rec_en_i` high. All other modes advance on `loc_en_i`. The enable that is not selected has no effect. `bit_en_o` is high, combinationally, exactly in the cycles that advance a bit period.
- R3: In modes 1 to 3, `ser_i` is sampled in each bit-period cycle. It appears on `tx_bit_o` with `tx_vld_o` high for one cycle in the following clock cycle.
- R4: Bits are numbered 0 to 1535. The number restarts at 0 after either reset. `frame_o` is high together with `tx_vld_o` for exactly the output of bit 1535, and is low otherwise.
- R5: In modes 4 to 6, `nib_clk_o` is high in the bit-period cycle of the first bit of each nibble. This is every fourth bit period, counted from reset.
  - `nib_i` is captured in that cycle and is ignored in the other three bit periods.
  - The captured nibble is output most significant bit first: `nib_i[3]`, then `nib_i[2]`, `nib_i[1]` and `nib_i[0]`.
  - Each bit appears on `tx_bit_o` one cycle after its bit period.
- R6: In modes 2 and 5, a rising edge of `frame_ref_i` makes the next bit period bit 0. A rising edge is high in a clock cycle after being low in the previous one. In mode 5 that next bit period is also the first bit of a new nibble.
- R7: In modes 1, 3, 4 and 6, `frame_ref_i` has no effect on the bit numbering.
- R8: While `srst_i` is high, no bit period is processed, and `tx_vld_o` and `frame_o` are low in the following cycle. After `srst_i` falls, the bit number and the nibble phase both restart at 0.
- R9: `tx_vld_o` is never high unless the previous cycle advanced a bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset; loads the mode |
| mode_i | input | 3 | Operating mode code |
| rec_en_i | input | 1 | Bit-period strobe of the recovered clock |
| loc_en_i | input | 1 | Bit-period strobe of the local clock |
| frame_ref_i | input | 1 | Frame reference input |
| ser_i | input | 1 | Serial payload bit |
| nib_i | input | 4 | Nibble payload |
| bit_en_o | output | 1 | Bit-period strobe towards the system side |
| nib_clk_o | output | 1 | Nibble strobe towards the system side |
| tx_bit_o | output | 1 | Captured payload bit towards the framer |
| tx_vld_o | output | 1 | `tx_bit_o` holds a new bit |
| frame_o | output | 1 | Last bit of the frame |

## Verification
The bench runs each mode past a full frame wrap. A counter that is off by one, or that fails to wrap, moves or drops the `frame_o` pulse.

It drives the enable that is not selected, and it toggles `nib_i` outside the capture slot. A design that picks the wrong timing source emits extra bits, and one that samples the nibble late emits garbage.

It also:
- sends frame reference edges mid-frame, and mid-nibble in mode 5, so that a missing realignment or a missing phase reset shows up as a misplaced frame pulse or scrambled bit order;
- sends reference edges in the free-running modes, where realigning would wrongly move the pulse;
- changes `mode_i` without a synchronous reset, which must keep the old mode;
- uses codes 0 and 7, to catch reserved codes that are not mapped to mode 1.

// File: rtl/e3_tx_pkg.sv
package e3_tx_pkg;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic nibble;
    logic loop_tmd;
    logic aligned;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_DEFAULT = '{nibble: 1'b0, loop_tmd: 1'b1, aligned: 1'b0};

  function automatic tx_cfg_t decode_mode(input logic [MODE_W-1:0] code);
    tx_cfg_t c;
    case (code)
      3'd2:    c = '{nibble: 1'b0, loop_tmd: 1'b0, aligned: 1'b1};
      3'd3:    c = '{nibble: 1'b0, loop_tmd: 1'b0, aligned: 1'b0};
      3'd4:    c = '{nibble: 1'b1, loop_tmd: 1'b1, aligned: 1'b0};
      3'd5:    c = '{nibble: 1'b1, loop_tmd: 1'b0, aligned: 1'b1};
      3'd6:    c = '{nibble: 1'b1, loop_tmd: 1'b0, aligned: 1'b0};
      default: c = CFG_DEFAULT;  // 0, 1, 7
    endcase
    return c;
  endfunction
endpackage

// File: rtl/e3_mode_reg.sv
module e3_mode_reg
  import e3_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [MODE_W-1:0] mode_i,
  output tx_cfg_t           cfg_o
);
  tx_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= CFG_DEFAULT;
    else if (srst_i) cfg_q <= decode_mode(mode_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/e3_bit_ctr.sv
module e3_bit_ctr #(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic tick_i,
  input  logic realign_i,
  input  logic nib_mode_i,
  output logic last_o,
  output logic nib_first_o
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam int PH_W  = (NIB_W > 1) ? $clog2(NIB_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NIB_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;

  assign last_o      = (cnt_q == CNT_LAST);
  assign nib_first_o = (ph_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (srst_i || realign_i) cnt_q <= '0;
    else if (tick_i)              cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  // nibble phase restarts with the frame so nibble and frame edges line up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ph_q <= '0;
    else if (srst_i || realign_i)    ph_q <= '0;
    else if (tick_i && nib_mode_i)   ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/e3_nib_ser.sv
module e3_nib_ser #(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             bit_o
);
  logic [NIB_W-1:0] sh_q;

  // first bit bypasses the register so the nibble is used in its capture slot
  assign bit_o = load_i ? nib_i[NIB_W-1] : sh_q[NIB_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (srst_i)   sh_q <= '0;
    else if (load_i)   sh_q <= {nib_i[NIB_W-2:0], 1'b0};
    else if (shift_i)  sh_q <= {sh_q[NIB_W-2:0], 1'b0};
  end
endmodule

// File: rtl/e3_tx_payload_if.sv
module e3_tx_payload_if
  import e3_tx_pkg::*;
#(
  parameter int FRAME_BITS = 1536,
  parameter int NIB_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rec_en_i,
  input  logic              loc_en_i,
  input  logic              frame_ref_i,
  input  logic              ser_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic              bit_en_o,
  output logic              nib_clk_o,
  output logic              tx_bit_o,
  output logic              tx_vld_o,
  output logic              frame_o
);
  tx_cfg_t cfg;
  logic    tick, ref_q, ref_rise, realign;
  logic    last, nib_first, nib_bit, data_bit;
  logic    bit_q, vld_q, frame_q;

  e3_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst_i),
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  assign tick = !srst_i && (cfg.loop_tmd ? rec_en_i : loc_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= frame_ref_i;
  end

  assign ref_rise = frame_ref_i && !ref_q;
  assign realign  = cfg.aligned && ref_rise && !srst_i;

  e3_bit_ctr #(.FRAME_BITS(FRAME_BITS), .NIB_W(NIB_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst_i),
    .tick_i      (tick),
    .realign_i   (realign),
    .nib_mode_i  (cfg.nibble),
    .last_o      (last),
    .nib_first_o (nib_first)
  );

  e3_nib_ser #(.NIB_W(NIB_W)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst_i),
    .load_i  (tick && cfg.nibble && nib_first),
    .shift_i (tick && cfg.nibble && !nib_first),
    .nib_i   (nib_i),
    .bit_o   (nib_bit)
  );

  assign data_bit = cfg.nibble ? nib_bit : ser_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
      frame_q <= 1'b0;
    end else if (srst_i) begin
      bit_q   <= 1'b0;
      vld_q   <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      vld_q   <= tick;
      frame_q <= tick && last;
      if (tick) bit_q <= data_bit;
    end
  end

  assign bit_en_o  = tick;
  assign nib_clk_o = tick && cfg.nibble && nib_first;
  assign tx_bit_o  = bit_q;
  assign tx_vld_o  = vld_q;
  assign frame_o   = frame_q;
endmodule

// File: rtl/e3_tx_payload_if_chk.sv
module e3_tx_payload_if_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic srst_i,
  input logic rec_en_i,
  input logic loc_en_i,
  input logic bit_en_o,
  input logic nib_clk_o,
  input logic tx_vld_o,
  input logic frame_o
);
  // R4
  frame_with_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |-> tx_vld_o);
  // R4
  frame_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);
  // R9
  vld_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_o |-> $past(rec_en_i || loc_en_i));
  // R8
  srst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (!tx_vld_o && !frame_o));
  // R8
  srst_no_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |-> !bit_en_o);
  // R5
  nib_in_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_clk_o |-> bit_en_o);
  // R2
  bit_en_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |-> (rec_en_i || loc_en_i));
endmodule

bind e3_tx_payload_if e3_tx_payload_if_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .srst_i    (srst_i),
  .rec_en_i  (rec_en_i),
  .loc_en_i  (loc_en_i),
  .bit_en_o  (bit_en_o),
  .nib_clk_o (nib_clk_o),
  .tx_vld_o  (tx_vld_o),
  .frame_o   (frame_o)
);

// File: tb/e3_tx_payload_if_tb_top.sv
module e3_tx_payload_if_tb_top;
  localparam int FB = 1536;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0;
  logic [2:0] mode_i = 3'd1;
  logic       rec_en_i = 1'b0, loc_en_i = 1'b0, frame_ref_i = 1'b0, ser_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic       bit_en_o, nib_clk_o, tx_bit_o, tx_vld_o, frame_o;

  e3_tx_payload_if dut_i (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];   // {bit, frame}

  // bench model state
  bit m_nib, m_loop, m_al;
  int bc = 0, ph = 0;
  logic [3:0] hold = 4'h0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int m);
    case (m)
      2: begin m_nib = 0; m_loop = 0; m_al = 1; end
      3: begin m_nib = 0; m_loop = 0; m_al = 0; end
      4: begin m_nib = 1; m_loop = 1; m_al = 0; end
      5: begin m_nib = 1; m_loop = 0; m_al = 1; end
      6: begin m_nib = 1; m_loop = 0; m_al = 0; end
      default: begin m_nib = 0; m_loop = 1; m_al = 0; end
    endcase
  endtask

  task automatic do_srst(input int m);
    @(negedge clk_i);
    mode_i = 3'(m);
    srst_i = 1'b1;
    rec_en_i = 1'b1; loc_en_i = 1'b1;  // R8: must be ignored during srst
    #1 chk(bit_en_o == 1'b0, "R8 bit_en during srst", bit_en_o, 0);
    @(negedge clk_i);
    srst_i = 1'b0; rec_en_i = 1'b0; loc_en_i = 1'b0;
    chk(tx_vld_o == 1'b0 && frame_o == 1'b0, "R8 outputs after srst", tx_vld_o, 0);
    set_cfg(m);
    bc = 0; ph = 0;
  endtask

  task automatic drive_bit(input logic [3:0] n);
    logic b;
    @(negedge clk_i);
    if (m_loop) rec_en_i = 1'b1; else loc_en_i = 1'b1;
    ser_i = n[0];
    nib_i = (ph == 0) ? n : ~n;
    #1;
    chk(bit_en_o == 1'b1, "R2 bit_en", bit_en_o, 1);
    if (m_nib) begin
      chk(nib_clk_o == (ph == 0), "R5 nib_clk", nib_clk_o, int'(ph == 0));
      if (ph == 0) hold = n;
      b = hold[3-ph];
      ph = (ph + 1) % 4;
    end else begin
      chk(nib_clk_o == 1'b0, "R2 nib_clk serial", nib_clk_o, 0);
      b = n[0];
    end
    exp_q.push_back({b, bc == FB - 1});
    bc = (bc + 1) % FB;
    @(negedge clk_i);
    rec_en_i = 1'b0; loc_en_i = 1'b0;
  endtask

  // R2: the unselected enable must not advance anything
  task automatic wrong_en();
    @(negedge clk_i);
    if (m_loop) loc_en_i = 1'b1; else rec_en_i = 1'b1;
    ser_i = $urandom; nib_i = 4'($urandom);
    #1 chk(bit_en_o == 1'b0, "R2 unselected enable", bit_en_o, 0);
    @(negedge clk_i);
    rec_en_i = 1'b0; loc_en_i = 1'b0;
  endtask

  task automatic ref_pulse();
    @(negedge clk_i); frame_ref_i = 1'b1;
    @(negedge clk_i); frame_ref_i = 1'b0;
    if (m_al) begin bc = 0; ph = 0; end   // R6; R7 otherwise
  endtask

  task automatic run_bits(input int n);
    for (int i = 0; i < n; i++) begin
      drive_bit(4'($urandom));
      if (i % 97 == 5) wrong_en();
    end
  endtask

  // monitor / scoreboard
  initial begin
    logic [1:0] e;
    forever begin
      @(posedge clk_i); #1;
      if (rst_ni && tx_vld_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected tx_vld", 1, 0);
        end else begin
          e = exp_q.pop_front();
          chk(tx_bit_o == e[1], m_nib ? "R5 bit" : "R3 bit", tx_bit_o, e[1]);
          chk(frame_o == e[0], "R4 frame on bit", frame_o, e[0]);
        end
      end else if (rst_ni) begin
        if (frame_o) chk(1'b0, "R4 frame without vld", frame_o, 0);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    set_cfg(1);
    repeat (3) @(negedge clk_i);
    chk(tx_vld_o == 0 && frame_o == 0 && bit_en_o == 0, "R8 reset state", tx_vld_o, 0);
    rst_ni = 1'b1;
    // async reset defaults to mode 1 (R1, R8)
    run_bits(FB + 4);

    // R1: mode_i change without srst has no effect
    @(negedge clk_i); mode_i = 3'd5;
    run_bits(40);
    wrong_en();

    // R2/R3/R6: mode 2
    do_srst(2);
    run_bits(30);
    ref_pulse();
    run_bits(700);
    ref_pulse();
    run_bits(FB + 3);

    // R7: mode 3 ignores frame_ref
    do_srst(3);
    run_bits(200);
    ref_pulse();
    run_bits(FB);

    // R5: mode 4
    do_srst(4);
    ref_pulse();
    run_bits(FB + 8);

    // R6: mode 5, realign mid-nibble
    do_srst(5);
    run_bits(6);
    ref_pulse();
    run_bits(FB + 4);

    // R7: mode 6
    do_srst(6);
    run_bits(102);
    ref_pulse();
    run_bits(FB + 2);

    // R1: reserved codes act as mode 1
    do_srst(7);
    run_bits(FB + 1);
    do_srst(0);
    ref_pulse();
    run_bits(50);

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 all bits delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule